// File: doc/BRIEF.md
# Host Word to Fixed-Point Converter

This block sits at the entry of a neural datapath and turns each 32-bit word written by the host into the 16-bit signed fixed-point format that the datapath works in. That format has 7 fractional bits. A per-word mode bit says how to read the word: as a two's-complement 32-bit integer, or as an IEEE-754 single-precision float. Every value leaves the block in fixed point, so the input queue behind it holds nothing else.

Both sides use a valid/ready handshake. The mode bit and the data word are captured in the same transfer, and the converted value appears one cycle later with its own valid flag. A single output register lets the block take a new word in the same cycle that its pending result is taken, so it sustains one word per cycle. Values that fall outside the representable range saturate. Float values are truncated toward zero.

Top module: `fcvt_top`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: in_ready equals (not out_valid) or out_ready. A word is accepted when in_valid and in_ready are both high at a rising edge. out_valid is high in the next cycle, and each accepted word produces exactly one output transfer, in acceptance order. In a cycle with in_ready high and in_valid low, out_valid goes low.
- R3: While out_valid is 1 and out_ready is 0, the next cycle keeps out_valid at 1 and out_fix unchanged, and no word is accepted. Changes to in_word or in_is_float in that time have no effect on the pending output.
- R4: With in_is_float = 0, in_word is read as a signed integer x. For -256 <= x <= 255, out_fix = x * 128 as a 16-bit two's-complement value.
- R5: In integer mode, x > 255 gives out_fix = 16'h7FFF and x < -256 gives out_fix = 16'h8000.
- R6: With in_is_float = 1, the word has sign in bit 31, biased exponent (bias 127) in bits 30:23 and mantissa in bits 22:0. For a normal float with value v, out_fix = trunc(v * 128) toward zero, as long as that result lies in [-32768, 32767].
- R7: A normal float whose truncated v * 128 exceeds 32767 gives 16'h7FFF, and one below -32768 gives 16'h8000.
- R8: A float with exponent field 0 (zero of either sign, or denormal) gives out_fix = 0.
- R9: A float with exponent field 255 and mantissa 0 (infinity) gives 16'h7FFF when positive and 16'h8000 when negative. A NaN (exponent 255, mantissa not 0) gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host word offered |
| in_ready | output | 1 | Converter can take a word this cycle |
| in_word | input | 32 | Host data word |
| in_is_float | input | 1 | 1: word is single-precision float, 0: signed integer |
| out_valid | output | 1 | Converted value present |
| out_ready | input | 1 | Consumer takes the value this cycle |
| out_fix | output | 16 | Signed fixed-point result, 7 fractional bits |

## Verification
Two things can happen in the same cycle: the pending result leaves on out_ready, and a new word with its mode bit enters on in_valid. When both occur, the register must drop the old value and load the new one without losing or repeating either. The bench forces this by driving out_ready and in_valid with two independent periodic gap patterns, so takes coincide with accepts, with stalls and with idle cycles across a sweep of every integer near the saturation limits and every float exponent. A scoreboard in acceptance order checks each output transfer against an arithmetic model, and every stalled cycle is checked for a frozen output and a low in_ready.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  // single-precision field layout
  localparam int F32_EXP_W = 8;
  localparam int F32_MAN_W = 23;
  localparam int F32_BIAS  = 127;
  localparam int HOST_W    = 32;

  typedef enum logic {
    FMT_INT = 1'b0,
    FMT_F32 = 1'b1
  } fmt_e;

  // side information about how a value was produced
  typedef struct packed {
    logic clip_hi;   // saturated to the positive limit
    logic clip_lo;   // saturated to the negative limit
    logic forced_0;  // zero, denormal or NaN forced to 0
  } cvt_flags_t;

endpackage

// File: rtl/fcvt_int.sv
module fcvt_int
  import fcvt_pkg::*;
#(
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 7
) (
  input  logic [HOST_W-1:0] word,
  output logic [OUT_W-1:0]  val,
  output cvt_flags_t        flags
);

  localparam int HI_LIM = ((1 << (OUT_W-1)) - 1) >> FRAC_W;
  localparam int LO_LIM = -(HI_LIM + 1);
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  function automatic logic [OUT_W-1:0] scale_int(input logic [HOST_W-1:0] w);
    return {w[OUT_W-FRAC_W-1:0], {FRAC_W{1'b0}}};
  endfunction

  logic signed [HOST_W-1:0] x;
  assign x = $signed(word);

  always_comb begin
    flags          = '0;
    flags.clip_hi  = (x > HI_LIM);
    flags.clip_lo  = (x < LO_LIM);
    if (flags.clip_hi)      val = POS_MAX;
    else if (flags.clip_lo) val = NEG_MAX;
    else                    val = scale_int(word);
  end

endmodule

// File: rtl/fcvt_f32.sv
module fcvt_f32
  import fcvt_pkg::*;
#(
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 7
) (
  input  logic [HOST_W-1:0] word,
  output logic [OUT_W-1:0]  val,
  output cvt_flags_t        flags
);

  localparam int SIG_W = F32_MAN_W + 1;
  // exponent at or above this value means magnitude >= 2^MAN_W after scaling
  localparam int THR   = F32_BIAS + F32_MAN_W - FRAC_W;
  localparam logic [F32_EXP_W-1:0] THR_E = F32_EXP_W'(THR);
  localparam logic [SIG_W-1:0] MAG_POS = SIG_W'((1 << (OUT_W-1)) - 1);
  localparam logic [SIG_W-1:0] MAG_NEG = SIG_W'(1 << (OUT_W-1));
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  logic                 sgn;
  logic [F32_EXP_W-1:0] expo;
  logic [F32_MAN_W-1:0] man;
  assign sgn  = word[HOST_W-1];
  assign expo = word[HOST_W-2 -: F32_EXP_W];
  assign man  = word[F32_MAN_W-1:0];

  // magnitude of value * 2^FRAC_W truncated toward zero (valid when expo < THR)
  function automatic logic [SIG_W-1:0] align_mag(input logic [F32_EXP_W-1:0] e,
                                                 input logic [F32_MAN_W-1:0] m);
    logic [F32_EXP_W-1:0] rsh;
    rsh = THR_E - e;
    return {1'b1, m} >> rsh;
  endfunction

  logic [SIG_W-1:0] mag;
  logic [SIG_W-1:0] neg_mag;
  logic             big;
  assign mag     = align_mag(expo, man);
  assign neg_mag = -mag;
  assign big     = (expo >= THR_E);

  always_comb begin
    flags = '0;
    val   = '0;
    if (expo == '0) begin
      flags.forced_0 = 1'b1;
    end else if (expo == '1) begin
      if (man != '0) begin
        flags.forced_0 = 1'b1;
      end else if (sgn) begin
        flags.clip_lo = 1'b1;
        val           = NEG_MAX;
      end else begin
        flags.clip_hi = 1'b1;
        val           = POS_MAX;
      end
    end else if (!sgn) begin
      if (big || mag > MAG_POS) begin
        flags.clip_hi = 1'b1;
        val           = POS_MAX;
      end else begin
        val = mag[OUT_W-1:0];
      end
    end else begin
      if (big || mag > MAG_NEG) begin
        flags.clip_lo = 1'b1;
        val           = NEG_MAX;
      end else begin
        val = neg_mag[OUT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/fcvt_stage.sv
module fcvt_stage
  import fcvt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  input  cvt_flags_t   up_flags,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data,
  output cvt_flags_t   dn_flags
);

  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
      dn_flags <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) begin
        dn_data  <= up_data;
        dn_flags <= up_flags;
      end
    end
  end

endmodule

// File: rtl/fcvt_top.sv
module fcvt_top
  import fcvt_pkg::*;
#(
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HOST_W-1:0] in_word,
  input  logic              in_is_float,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_fix
);

  logic [OUT_W-1:0] int_val, flt_val, sel_val;
  cvt_flags_t       int_flags, flt_flags, sel_flags;
  cvt_flags_t       held_flags;
  fmt_e             fmt;

  // named events for the checker
  logic accept_ev;
  logic take_ev;
  logic stall_ev;

  assign fmt = fmt_e'(in_is_float);

  fcvt_int #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) int_u (
    .word (in_word),
    .val  (int_val),
    .flags(int_flags)
  );

  fcvt_f32 #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) flt_u (
    .word (in_word),
    .val  (flt_val),
    .flags(flt_flags)
  );

  always_comb begin
    if (fmt == FMT_F32) begin
      sel_val   = flt_val;
      sel_flags = flt_flags;
    end else begin
      sel_val   = int_val;
      sel_flags = int_flags;
    end
  end

  fcvt_stage #(.W(OUT_W)) stage_u (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data (sel_val),
    .up_flags(sel_flags),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (out_fix),
    .dn_flags(held_flags)
  );

  assign accept_ev = in_valid && in_ready;
  assign take_ev   = out_valid && out_ready;
  assign stall_ev  = out_valid && !out_ready;

endmodule

// File: rtl/fcvt_chk.sv
module fcvt_chk
  import fcvt_pkg::*;
#(
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [HOST_W-1:0] in_word,
  input logic              in_is_float,
  input logic              out_valid,
  input logic [OUT_W-1:0]  out_fix,
  input logic              accept_ev,
  input logic              take_ev,
  input logic              stall_ev,
  input cvt_flags_t        held_flags
);

  localparam int HI_LIM = ((1 << (OUT_W-1)) - 1) >> FRAC_W;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};

  // R3
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ev |=> out_valid && $stable(out_fix));

  // R3
  no_accept_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ev |-> !in_ready);

  // R2
  accept_gives_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> out_valid);

  // R2
  idle_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);

  // R2
  take_frees_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |-> in_ready);

  // R5
  int_clip_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && !in_is_float && ($signed(in_word) > HI_LIM)) |=> out_fix == POS_MAX);

  // R6
  flt_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && in_is_float && !in_word[HOST_W-1]) |=> !out_fix[OUT_W-1]);

  // R8
  flt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && in_is_float && in_word[HOST_W-2 -: F32_EXP_W] == '0) |=> out_fix == '0);

  // R9
  flt_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && in_is_float && in_word[HOST_W-2 -: F32_EXP_W] == '1 &&
     in_word[F32_MAN_W-1:0] != '0) |=> out_fix == '0);

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(held_flags));

endmodule

bind fcvt_top fcvt_chk #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_word    (in_word),
  .in_is_float(in_is_float),
  .out_valid  (out_valid),
  .out_fix    (out_fix),
  .accept_ev  (accept_ev),
  .take_ev    (take_ev),
  .stall_ev   (stall_ev),
  .held_flags (held_flags)
);

// File: tb/fcvt_top_tb.sv
module fcvt_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_INT      = 1028;
  localparam int N_FLT      = 2048;
  localparam int NVEC       = N_INT + N_FLT;
  localparam int CYC_LIMIT  = 50000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        in_is_float;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_fix;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcvt_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_word    (in_word),
    .in_is_float(in_is_float),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_fix    (out_fix)
  );

  int ntest = 0;
  int nfail = 0;

  logic [15:0] exp_val [0:4095];
  string       exp_tag [0:4095];
  int          q_head = 0;
  int          q_tail = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [32:0] vec(input int i);
    logic [22:0] m;
    int          f;
    if (i < 1024) return {1'b0, 32'(i - 512)};
    case (i)
      1024: return {1'b0, 32'h7FFF_FFFF};
      1025: return {1'b0, 32'h8000_0000};
      1026: return {1'b0, 32'd256};
      default: return {1'b0, 32'hFFFF_FEFF}; // -257
      1027: return {1'b0, 32'hFFFF_FF00};    // -256
      1028, 1029, 1030, 1031, 1032: ;
    endcase
    return '0;
  endfunction

  function automatic logic [32:0] fvec(input int f);
    logic [22:0] m;
    case (f[9:8])
      2'd0: m = 23'h000000;
      2'd1: m = 23'h400000;
      2'd2: m = 23'h7FFFFF;
      default: m = 23'h000001;
    endcase
    return {1'b1, f[10], f[7:0], m};
  endfunction

  function automatic logic [32:0] get_vec(input int i);
    if (i < N_INT) return vec(i);
    return fvec(i - N_INT);
  endfunction

  // arithmetic model of the requirements
  function automatic logic [15:0] model(input logic [32:0] v, output string tag);
    logic [31:0] w;
    longint      s;
    int          e;
    real         r;
    w = v[31:0];
    if (!v[32]) begin
      s = longint'($signed(w)) * 128;
      if (s > 32767)       begin tag = "R5"; return 16'h7FFF; end
      else if (s < -32768) begin tag = "R5"; return 16'h8000; end
      tag = "R4";
      return 16'(s);
    end
    e = int'(w[30:23]);
    if (e == 0) begin tag = "R8"; return 16'h0000; end
    if (e == 255) begin
      tag = "R9";
      if (w[22:0] != 0) return 16'h0000;
      return w[31] ? 16'h8000 : 16'h7FFF;
    end
    r = 1.0 + real'(w[22:0]) / 8388608.0;
    for (int k = 127; k < e; k++) r = r * 2.0;
    for (int k = e; k < 127; k++) r = r / 2.0;
    r = r * 128.0;
    if (w[31]) r = -r;
    if (r >= 32768.0)  begin tag = "R7"; return 16'h7FFF; end
    if (r <= -32769.0) begin tag = "R7"; return 16'h8000; end
    tag = "R6";
    return 16'($rtoi(r));
  endfunction

  initial begin
    int          vi;
    int          cyc;
    bit          stalled;
    logic [15:0] held;
    logic [32:0] v;
    string       t;
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    in_word     = '0;
    in_is_float = 1'b0;
    out_ready   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);

    vi      = 0;
    cyc     = 0;
    stalled = 0;
    held    = '0;
    while (vi < NVEC || q_tail != q_head) begin
      out_ready = !((cyc % 7) == 3 || (cyc % 11) == 5);
      if (vi < NVEC && (cyc % 13) != 6) begin
        v           = get_vec(vi);
        in_valid    = 1'b1;
        in_is_float = v[32];
        in_word     = v[31:0];
      end else begin
        in_valid    = 1'b0;
        in_is_float = ~in_is_float;
        in_word     = ~in_word;
      end
      #1;
      if (stalled) begin
        check(out_valid == 1'b1, "R3 valid held in stall", longint'(out_valid), 1);
        check(out_fix == held, "R3 data held in stall", longint'(out_fix), longint'(held));
      end
      if (out_valid && !out_ready)
        check(in_ready == 1'b0, "R3 no accept in stall", longint'(in_ready), 0);
      if (!out_valid || out_ready)
        check(in_ready == 1'b1, "R2 in_ready when free", longint'(in_ready), 1);
      if (out_valid && out_ready) begin
        if (q_tail == q_head) begin
          check(1'b0, "R2 output without accepted word", longint'(out_fix), -1);
        end else begin
          check(out_fix == exp_val[q_head % 4096],
                {exp_tag[q_head % 4096], " converted value"},
                longint'($signed(out_fix)), longint'($signed(exp_val[q_head % 4096])));
          q_head++;
        end
      end
      stalled = out_valid && !out_ready;
      held    = out_fix;
      if (in_valid && in_ready) begin
        exp_val[q_tail % 4096] = model({in_is_float, in_word}, t);
        exp_tag[q_tail % 4096] = t;
        q_tail++;
        vi++;
      end
      cyc++;
      if (cyc > CYC_LIMIT) begin
        check(1'b0, "R2 watchdog expired", longint'(cyc), CYC_LIMIT);
        break;
      end
      @(negedge clk);
    end

    // after draining with no input, output must be idle
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R2 idle after drain", longint'(out_valid), 0);

    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

endmodule